// File: doc/BRIEF.md
# TDM Frame Serial-to-Parallel Receiver

This block takes a serial time-division-multiplexed bit stream and a one-bit frame marker, both sampled on the bit clock. A frame holds 256 bits split into 32 time slots of 8 bits each. At 2.048 Mbit/s this gives 8000 frames per second, one frame every 125 µs. The marker is high during the first bit of each frame. The receiver recovers the bytes from three signals only: the clock, the data and the marker.

A frame position counter tracks where the current bit sits in the frame. Each time the marker is sampled high, the counter restarts at position zero. Incoming bits collect in a shift register. After the last bit of each slot, the assembled byte is copied to the output together with its slot number, and a valid strobe marks it. A lock flag shows whether the markers keep arriving exactly where the counter expects a frame to start.

Top module: `tdm_rx`

## Requirements
- R1: While reset is asserted, and after it is released, `byte_o`, `slot_o`, `byte_valid_o` and `locked_o` are all 0.
- R2: When `sync_i` is sampled high, the bit sampled in that same cycle is bit 0 of slot 0, whatever the counter held before. The byte that starts with it is reported with `slot_o` = 0.
- R3: Bits are received most significant first. The first bit of a slot lands in `byte_o[7]` and the eighth bit lands in `byte_o[0]`.
- R4: The cycle after the eighth bit of a slot is sampled, `byte_valid_o` is high for exactly one cycle. In that cycle `byte_o` holds the new byte and `slot_o` holds the index of the slot (frame position divided by 8).
- R5: Slot indices run 0 to 31 in order. After 256 bits the counter wraps to slot 0 on its own, even when no marker arrives.
- R6: `byte_valid_o` stays low until `sync_i` has been sampled high at least once after reset.
- R7: `locked_o` goes high when `sync_i` is sampled at the position where the counter expects bit 0 of a frame, provided an earlier marker has already been seen. A single marker after reset does not set it.
- R8: If `sync_i` is sampled high at any other position, `locked_o` is low from the next cycle, and counting restarts from that marker.
- R9: If the counter wraps to the frame start after a marker has been seen and `sync_i` is low on that bit, `locked_o` is low from the next cycle.
- R10: `byte_o` and `slot_o` hold their values in every cycle in which `byte_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; data and marker are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_i | input | 1 | Serial data, most significant bit of each slot first |
| sync_i | input | 1 | Frame marker, high during bit 0 of slot 0 |
| byte_o | output | 8 | Last assembled slot byte |
| slot_o | output | 5 | Slot index of `byte_o` |
| byte_valid_o | output | 1 | One-cycle strobe when a new byte is presented |
| locked_o | output | 1 | Markers arrive at the expected frame boundary |

## Verification
The assertions check several rules on every cycle. A marker must restart the position counter. A misplaced marker or a missing one must clear the lock. Lock may only rise on a marker. The valid strobe must be a single-cycle pulse that never appears before the first marker, and the byte and slot must stay constant while no strobe is present. Other properties depend on data and can only be shown by the bench scenarios: bit order within the byte, the exact byte value tagged with each slot, the slot sequence across a frame wrap, and realignment after a marker arrives off position. The bench also covers a lock that is lost and then regained over a series of frames.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int unsigned SLOT_BITS_DEF = 8;
  localparam int unsigned NUM_SLOTS_DEF = 32;
endpackage

// File: rtl/tdm_frame_pos.sv
module tdm_frame_pos #(
  parameter int unsigned POS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  output logic [POS_W-1:0] cur_pos_o,
  output logic             seen_o,
  output logic             locked_o
);
  // pos_q: position the counter expects for the bit sampled this cycle
  logic [POS_W-1:0] pos_q;
  logic             seen_q, locked_q;
  logic             at_start;

  assign cur_pos_o = sync_i ? '0 : pos_q;
  assign at_start  = (pos_q == '0);
  assign seen_o    = seen_q;
  assign locked_o  = locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      seen_q   <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      pos_q  <= cur_pos_o + POS_W'(1);
      seen_q <= seen_q | sync_i;
      if (sync_i)                locked_q <= seen_q & at_start;
      else if (seen_q && at_start) locked_q <= 1'b0;
    end
  end

  a_r2_sync_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (pos_q == POS_W'(1)));
  a_r8_misplaced_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && !at_start) |=> !locked_o);
  a_r9_missing_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && at_start && !sync_i) |=> !locked_o);
  a_r7_lock_on_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(sync_i));
endmodule

// File: rtl/tdm_slot_deser.sv
module tdm_slot_deser #(
  parameter int unsigned SLOT_BITS = 8,
  parameter int unsigned SLOT_W    = 5,
  parameter int unsigned BIT_W     = 3,
  localparam int unsigned POS_W    = SLOT_W + BIT_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ser_i,
  input  logic [POS_W-1:0]     cur_pos_i,
  input  logic                 seen_i,
  output logic [SLOT_BITS-1:0] byte_o,
  output logic [SLOT_W-1:0]    slot_o,
  output logic                 valid_o
);
  logic [SLOT_BITS-2:0] shreg_q;
  logic                 emit;

  assign emit = seen_i && (cur_pos_i[BIT_W-1:0] == BIT_W'(SLOT_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      byte_o  <= '0;
      slot_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      shreg_q <= {shreg_q[SLOT_BITS-3:0], ser_i};
      valid_o <= emit;
      if (emit) begin
        byte_o <= {shreg_q, ser_i};
        slot_o <= cur_pos_i[POS_W-1:BIT_W];
      end
    end
  end

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r6_quiet_before_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_i |-> !valid_o);
  a_r10_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(byte_o) && $stable(slot_o)));
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx
  import tdm_rx_pkg::*;
#(
  parameter int unsigned SLOT_BITS = SLOT_BITS_DEF,
  parameter int unsigned NUM_SLOTS = NUM_SLOTS_DEF,
  localparam int unsigned BIT_W    = $clog2(SLOT_BITS),
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS),
  localparam int unsigned POS_W    = BIT_W + SLOT_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ser_i,
  input  logic                 sync_i,
  output logic [SLOT_BITS-1:0] byte_o,
  output logic [SLOT_W-1:0]    slot_o,
  output logic                 byte_valid_o,
  output logic                 locked_o
);
  logic [POS_W-1:0] cur_pos;
  logic             seen;

  tdm_frame_pos #(.POS_W(POS_W)) i_frame_pos (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (sync_i),
    .cur_pos_o (cur_pos),
    .seen_o    (seen),
    .locked_o  (locked_o)
  );

  tdm_slot_deser #(.SLOT_BITS(SLOT_BITS), .SLOT_W(SLOT_W), .BIT_W(BIT_W)) i_slot_deser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ser_i     (ser_i),
    .cur_pos_i (cur_pos),
    .seen_i    (seen),
    .byte_o    (byte_o),
    .slot_o    (slot_o),
    .valid_o   (byte_valid_o)
  );
endmodule

// File: tb/test_tdm_rx.sv
module test_tdm_rx;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ser_i = 1'b0;
  logic       sync_i = 1'b0;
  logic [7:0] byte_o;
  logic [4:0] slot_o;
  logic       byte_valid_o;
  logic       locked_o;

  int checks = 0;
  int fails  = 0;
  int hold_err = 0;
  int pulse_err = 0;
  logic [12:0] cap[$];
  logic [7:0]  prev_byte;
  logic [4:0]  prev_slot;
  logic        prev_valid;
  logic        mon_on = 1'b0;

  typedef struct packed {
    logic [3:0] lead;   // junk bits sent before the frame
    logic       sync;   // marker on first frame bit
    logic       locked; // expected lock after the frame
  } row_t;

  localparam row_t ROWS [6] = '{
    '{lead: 4'd0, sync: 1'b1, locked: 1'b0},  // first marker
    '{lead: 4'd0, sync: 1'b1, locked: 1'b1},  // on time
    '{lead: 4'd0, sync: 1'b0, locked: 1'b0},  // missing at wrap
    '{lead: 4'd0, sync: 1'b1, locked: 1'b1},  // regained at wrap
    '{lead: 4'd3, sync: 1'b1, locked: 1'b0},  // misplaced
    '{lead: 4'd0, sync: 1'b1, locked: 1'b1}   // relocked
  };
  localparam logic [7:0] PAT [8] = '{8'h80, 8'h01, 8'hFF, 8'h00, 8'hA5, 8'h5A, 8'hC3, 8'h3C};

  tdm_rx i_tdm_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .ser_i(ser_i), .sync_i(sync_i),
    .byte_o(byte_o), .slot_o(slot_o), .byte_valid_o(byte_valid_o), .locked_o(locked_o)
  );

  always #5 clk_i = ~clk_i;

  function automatic logic [7:0] exp_byte(int row, int s);
    return PAT[s % 8] ^ 8'(row * 29) ^ 8'(s);
  endfunction

  // monitor, 1 ns after the edge
  always @(posedge clk_i) begin
    #1;
    if (mon_on) begin
      if (byte_valid_o) cap.push_back({slot_o, byte_o});
      if (!byte_valid_o && (byte_o != prev_byte || slot_o != prev_slot)) hold_err++;
      if (byte_valid_o && prev_valid) pulse_err++;
    end
    prev_byte  = byte_o;
    prev_slot  = slot_o;
    prev_valid = byte_valid_o;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic d, logic s);
    @(negedge clk_i);
    ser_i  = d;
    sync_i = s;
  endtask

  task automatic settle();
    @(posedge clk_i);
    #2;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] last;
    repeat (3) @(posedge clk_i);
    #2;
    check("R1 byte", 32'(byte_o), 0);
    check("R1 slot", 32'(slot_o), 0);
    check("R1 valid", 32'(byte_valid_o), 0);
    check("R1 locked", 32'(locked_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    settle();
    check("R1 after release", 32'({byte_o, slot_o, byte_valid_o, locked_o}), 0);
    mon_on = 1'b1;

    // R6: bits with no marker produce nothing
    for (int i = 0; i < 40; i++) send_bit(1'(i % 3 == 0), 1'b0);
    settle();
    check("R6 no valid before sync", 32'(cap.size()), 0);

    last = '0;
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < int'(ROWS[r].lead); i++) send_bit(1'b1, 1'b0);
      cap.delete();
      for (int s = 0; s < 32; s++) begin
        logic [7:0] b;
        b = exp_byte(r, s);
        for (int k = 7; k >= 0; k--)
          send_bit(b[k], ROWS[r].sync && s == 0 && k == 7);
      end
      settle();
      // R2/R3/R4/R5: one tagged byte per slot, MSB first, in order
      check("R4 byte count", 32'(cap.size()), 32);
      for (int s = 0; s < 32 && s < cap.size(); s++) begin
        check("R5 slot order", 32'(cap[s][12:8]), 32'(s));
        check("R3 byte value", 32'(cap[s][7:0]), 32'(exp_byte(r, s)));
      end
      if (r == 0) check("R2 slot 0 after sync", 32'(cap[0][12:8]), 0);
      if (r == 2) check("R9 lock lost on missing sync", 32'(locked_o), 0);
      else if (r == 4) check("R8 lock lost on misplaced sync", 32'(locked_o), 0);
      else check("R7 lock state", 32'(locked_o), 32'(ROWS[r].locked));
      last = exp_byte(r, 31);
    end

    // R10: held after the last byte, partial slot adds nothing
    cap.delete();
    for (int i = 0; i < 5; i++) send_bit(1'(i[0]), 1'b0);
    settle();
    check("R10 no new byte", 32'(cap.size()), 0);
    check("R10 byte held", 32'(byte_o), 32'(last));
    check("R10 slot held", 32'(slot_o), 31);
    check("R10 hold between strobes", 32'(hold_err), 0);
    check("R4 single-cycle pulse", 32'(pulse_err), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule